// File: doc/BRIEF.md
# Predictive Two-Level Voltage and Frequency Speed Controller

This block sits beside one processing cluster and selects its supply voltage level and clock frequency level while a task runs. A task is announced with a one-cycle load pulse that carries its instruction budget and its deadline, counted in sampling ticks. On every sampling tick the controller adds the work the cluster finished during that period to a running total. It then works out how much work is left and how many ticks remain. From these two values it decides whether the slow, low-voltage mode can still finish the task in time.

Every task opens in the fast, high-voltage mode. The controller drops to low voltage once the remaining work fits under the slower speed over the shrinking horizon. After that drop it does not climb back, except when the deadline is reached with work still left. No divider is used: "remaining work over remaining ticks exceeds speed" is evaluated as "remaining work exceeds speed times remaining ticks". While in low voltage, the two low-voltage frequencies are chosen with the same comparison. The clock is gated off when no task is active or when the work has been finished.

Top module: `dvfs_speed_ctrl`

## Requirements
- R1: After reset, clk_en is 0, volt_hi is 0, freq_sel is 0 (slow low-voltage frequency) and deadline_miss is 0.
- R2: On the cycle after task_load, volt_hi is 1, freq_sel is 2 (high-voltage frequency), clk_en is 1 and deadline_miss is 0, whatever the previous task left behind.
- R3: Each sampling tick of an active task adds work_done to the executed total and takes one from the remaining ticks. The decision made from these updated values appears on the outputs in the cycle after the tick.
- R4: While the controller has not yet dropped to low voltage, it keeps volt_hi=1 and freq_sel=2 whenever the remaining work exceeds speed_low_fast times the remaining ticks.
- R5: Otherwise it switches to volt_hi=0. In low voltage, freq_sel is 1 when the remaining work exceeds speed_low_slow times the remaining ticks, and 0 if not.
- R6: Once a task has dropped to low voltage, a shortfall in measured work never brings volt_hi back to 1 before the deadline is reached.
- R7: When the executed total reaches the budget, the next outputs are clk_en=0, volt_hi=0 and freq_sel=0. Ticks that arrive while no task is active change no output.
- R8: When the remaining ticks reach zero with work still left, deadline_miss becomes 1 and the outputs are forced to volt_hi=1 and freq_sel=2 until the work is done. deadline_miss stays 1 until the next task_load.
- R9: A task whose budget exceeds speed_low_fast times its tick count at every tick runs entirely at volt_hi=1 and freq_sel=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| task_load | input | 1 | One-cycle pulse that starts a new task |
| task_budget | input | 32 | Instruction budget of the new task |
| task_ticks | input | 20 | Deadline of the new task, in sampling ticks |
| tick | input | 1 | Sampling strobe, one cycle wide |
| work_done | input | 12 | Instructions executed in the sampling period just ended |
| speed_low_fast | input | 12 | Instructions per tick at low voltage, faster frequency |
| speed_low_slow | input | 12 | Instructions per tick at low voltage, slower frequency |
| volt_hi | output | 1 | 1 selects high voltage, 0 selects low voltage |
| freq_sel | output | 2 | 0 slow low-voltage, 1 fast low-voltage, 2 high-voltage frequency |
| clk_en | output | 1 | Clock enable for the cluster; 0 gates the clock off |
| deadline_miss | output | 1 | Set when the deadline passes with work left; held until the next load |

## Verification
The bench targets the exact tick where remaining work first falls to the low-speed product. A design with an off-by-one in the tick count or the comparison would drop to low voltage one tick early or late. A run where measured work stalls after the drop checks that the controller holds low voltage. A design without the one-way lock would bounce back to high voltage, paying for an extra transition. The bench also lets the deadline expire on an infeasible task and then on a stalled one. A wrong design would miss the forced high level, would raise the miss flag when work ends on the last tick, or would drop the flag before the next load. Idle ticks after completion must leave the gated clock off.

// File: rtl/dvfs_pkg.sv
// Shared encodings for the speed controller.
// Assumes freq_sel codes are decoded by the clock generator as listed here.
package dvfs_pkg;
    typedef enum logic [1:0] {
        FREQ_LOW_SLOW = 2'd0,
        FREQ_LOW_FAST = 2'd1,
        FREQ_HIGH     = 2'd2
    } freq_lvl_e;
endpackage

// File: rtl/dvfs_work_tracker.sv
// Holds the task budget, the executed-work total and the remaining ticks.
// Presents the values the next tick would produce (remaining work, ticks left).
// Assumes W_INSTR >= W_SPEED; the executed total saturates rather than wrapping.
module dvfs_work_tracker #(
    parameter int W_INSTR = 32,
    parameter int W_TICK  = 20,
    parameter int W_SPEED = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [W_INSTR-1:0] budget_in,
    input  logic [W_TICK-1:0]  ticks_in,
    input  logic               step,
    input  logic [W_SPEED-1:0] meas,
    output logic [W_INSTR-1:0] rem_next,
    output logic [W_TICK-1:0]  left_next
);
    localparam int PAD = W_INSTR - W_SPEED + 1;

    logic [W_INSTR-1:0] budget_q, exec_q, exec_n;
    logic [W_TICK-1:0]  left_q;
    logic [W_INSTR:0]   sum;

    // Next executed total (saturating), next tick count and remaining work.
    always_comb begin
        sum       = {1'b0, exec_q} + {{PAD{1'b0}}, meas};
        exec_n    = sum[W_INSTR] ? '1 : sum[W_INSTR-1:0];
        left_next = (left_q == '0) ? '0 : left_q - 1'b1;
        rem_next  = (budget_q > exec_n) ? budget_q - exec_n : '0;
    end

    // Latch a new task on load, advance the totals on each accepted tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            budget_q <= '0;
            exec_q   <= '0;
            left_q   <= '0;
        end else if (load) begin
            budget_q <= budget_in;
            exec_q   <= '0;
            left_q   <= ticks_in;
        end else if (step) begin
            exec_q   <= exec_n;
            left_q   <= left_next;
        end
    end
endmodule

// File: rtl/dvfs_speed_compare.sv
// Divider-free test of "remaining work / remaining ticks > speed":
// compares remaining work against speed * remaining ticks at full width.
module dvfs_speed_compare #(
    parameter int W_INSTR = 32,
    parameter int W_TICK  = 20,
    parameter int W_SPEED = 12
) (
    input  logic [W_INSTR-1:0] rem,
    input  logic [W_TICK-1:0]  left,
    input  logic [W_SPEED-1:0] speed,
    output logic               exceeds
);
    localparam int PW = W_SPEED + W_TICK;
    localparam int CW = (PW > W_INSTR) ? PW : W_INSTR;

    logic [PW-1:0] prod;

    // Product of speed and horizon, then an unsigned compare.
    always_comb begin
        prod    = PW'(speed) * PW'(left);
        exceeds = CW'(rem) > CW'(prod);
    end
endmodule

// File: rtl/dvfs_level_fsm.sv
// Chooses the voltage and frequency levels from the comparison results.
// Starts each task at the high level, drops to low voltage at most once,
// forces the high level and flags a miss when the horizon is exhausted.
module dvfs_level_fsm
    import dvfs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       tick,
    input  logic       rem_zero,
    input  logic       left_zero,
    input  logic       need_fast,
    input  logic       need_mid,
    output logic       active,
    output logic       volt_hi,
    output freq_lvl_e  freq_lvl,
    output logic       miss
);
    logic locked;

    // Level decision, registered once per accepted tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            locked   <= 1'b0;
            miss     <= 1'b0;
            volt_hi  <= 1'b0;
            freq_lvl <= FREQ_LOW_SLOW;
        end else if (load) begin
            active   <= 1'b1;
            locked   <= 1'b0;
            miss     <= 1'b0;
            volt_hi  <= 1'b1;
            freq_lvl <= FREQ_HIGH;
        end else if (tick && active) begin
            if (rem_zero) begin
                active   <= 1'b0;
                volt_hi  <= 1'b0;
                freq_lvl <= FREQ_LOW_SLOW;
            end else if (left_zero) begin
                miss     <= 1'b1;
                volt_hi  <= 1'b1;
                freq_lvl <= FREQ_HIGH;
            end else if (!locked && need_fast) begin
                volt_hi  <= 1'b1;
                freq_lvl <= FREQ_HIGH;
            end else begin
                locked   <= 1'b1;
                volt_hi  <= 1'b0;
                freq_lvl <= need_mid ? FREQ_LOW_FAST : FREQ_LOW_SLOW;
            end
        end
    end
endmodule

// File: rtl/dvfs_speed_ctrl.sv
// Top of the predictive two-level speed controller for one cluster.
// Assumes tick and task_load are single-cycle strobes; load wins over tick.
module dvfs_speed_ctrl
    import dvfs_pkg::*;
#(
    parameter int W_INSTR = 32,
    parameter int W_TICK  = 20,
    parameter int W_SPEED = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               task_load,
    input  logic [W_INSTR-1:0] task_budget,
    input  logic [W_TICK-1:0]  task_ticks,
    input  logic               tick,
    input  logic [W_SPEED-1:0] work_done,
    input  logic [W_SPEED-1:0] speed_low_fast,
    input  logic [W_SPEED-1:0] speed_low_slow,
    output logic               volt_hi,
    output logic [1:0]         freq_sel,
    output logic               clk_en,
    output logic               deadline_miss
);
    localparam int N_CMP = 2;

    logic [W_INSTR-1:0] rem_next;
    logic [W_TICK-1:0]  left_next;
    logic [W_SPEED-1:0] cmp_speed [N_CMP];
    logic [N_CMP-1:0]   cmp_hit;
    logic               active;
    freq_lvl_e          freq_lvl;

    // Threshold speeds: index 0 decides the voltage, index 1 the low frequency.
    always_comb begin
        cmp_speed[0] = speed_low_fast;
        cmp_speed[1] = speed_low_slow;
    end

    dvfs_work_tracker #(.W_INSTR(W_INSTR), .W_TICK(W_TICK), .W_SPEED(W_SPEED)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (task_load),
        .budget_in (task_budget),
        .ticks_in  (task_ticks),
        .step      (tick && active),
        .meas      (work_done),
        .rem_next  (rem_next),
        .left_next (left_next)
    );

    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
        dvfs_speed_compare #(.W_INSTR(W_INSTR), .W_TICK(W_TICK), .W_SPEED(W_SPEED)) u_cmp (
            .rem     (rem_next),
            .left    (left_next),
            .speed   (cmp_speed[g]),
            .exceeds (cmp_hit[g])
        );
    end

    dvfs_level_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (task_load),
        .tick      (tick),
        .rem_zero  (rem_next == '0),
        .left_zero (left_next == '0),
        .need_fast (cmp_hit[0]),
        .need_mid  (cmp_hit[1]),
        .active    (active),
        .volt_hi   (volt_hi),
        .freq_lvl  (freq_lvl),
        .miss      (deadline_miss)
    );

    // Output mapping: the clock runs only while a task is active.
    always_comb begin
        freq_sel = freq_lvl;
        clk_en   = active;
    end
endmodule

// File: rtl/dvfs_speed_ctrl_chk.sv
// Protocol checker for the speed controller, bound to the top module.
module dvfs_speed_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       task_load,
    input logic       volt_hi,
    input logic [1:0] freq_sel,
    input logic       clk_en,
    input logic       deadline_miss
);
    AST_LOAD_STARTS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        task_load |=> (volt_hi && freq_sel == 2'd2 && clk_en && !deadline_miss)); // R2

    AST_GATED_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |-> (!volt_hi && freq_sel == 2'd0)); // R7

    AST_NO_CLIMB_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !volt_hi && !task_load) |=> (!volt_hi || deadline_miss)); // R6

    AST_MISS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (deadline_miss && !task_load) |=> deadline_miss); // R8

    AST_MISS_FORCES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (deadline_miss && clk_en) |-> (volt_hi && freq_sel == 2'd2)); // R8

    AST_LEGAL_FREQ: assert property (@(posedge clk) disable iff (!rst_n)
        freq_sel != 2'd3); // R5
endmodule

bind dvfs_speed_ctrl dvfs_speed_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .task_load     (task_load),
    .volt_hi       (volt_hi),
    .freq_sel      (freq_sel),
    .clk_en        (clk_en),
    .deadline_miss (deadline_miss)
);

// File: tb/dvfs_speed_ctrl_test.sv
module dvfs_speed_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        task_load = 1'b0;
    logic [31:0] task_budget = '0;
    logic [19:0] task_ticks = '0;
    logic        tick = 1'b0;
    logic [11:0] work_done = '0;
    logic [11:0] speed_low_fast = 12'd60;
    logic [11:0] speed_low_slow = 12'd30;
    logic        volt_hi;
    logic [1:0]  freq_sel;
    logic        clk_en;
    logic        deadline_miss;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic       v;
        logic [1:0] f;
        logic       e;
        logic       m;
        string      tag;
    } exp_t;
    exp_t q[$];

    // Reference model state, derived from the requirements.
    longint m_budget, m_exec, m_left;
    bit     m_active, m_locked, m_miss;
    logic       m_v;
    logic [1:0] m_f;

    always #2 clk = ~clk;

    dvfs_speed_ctrl uut (
        .clk(clk), .rst_n(rst_n), .task_load(task_load), .task_budget(task_budget),
        .task_ticks(task_ticks), .tick(tick), .work_done(work_done),
        .speed_low_fast(speed_low_fast), .speed_low_slow(speed_low_slow),
        .volt_hi(volt_hi), .freq_sel(freq_sel), .clk_en(clk_en),
        .deadline_miss(deadline_miss)
    );

    function automatic exp_t cur(string tag);
        exp_t e;
        e.v = m_v; e.f = m_f; e.e = m_active; e.m = m_miss; e.tag = tag;
        return e;
    endfunction

    task automatic load_task(longint budget, longint ticks);
        @(negedge clk);
        task_load = 1'b1; task_budget = budget[31:0]; task_ticks = ticks[19:0];
        m_budget = budget; m_exec = 0; m_left = ticks;
        m_active = 1; m_locked = 0; m_miss = 0; m_v = 1; m_f = 2;
        @(posedge clk); #1;
        task_load = 1'b0;
        q.push_back(cur("R2 load starts high"));
    endtask

    task automatic do_tick(int meas, string tag);
        longint rem;
        string  why;
        @(negedge clk);
        tick = 1'b1; work_done = meas[11:0];
        why = tag;
        if (m_active) begin
            m_exec += meas;
            if (m_left > 0) m_left--;
            rem = (m_budget > m_exec) ? m_budget - m_exec : 0;
            if (rem == 0) begin
                m_active = 0; m_v = 0; m_f = 0; why = {tag, " R7 done"};
            end else if (m_left == 0) begin
                m_miss = 1; m_v = 1; m_f = 2; why = {tag, " R8 miss"};
            end else if (!m_locked && rem > longint'(speed_low_fast) * m_left) begin
                m_v = 1; m_f = 2; why = {tag, " R4 high"};
            end else begin
                m_locked = 1; m_v = 0;
                m_f = (rem > longint'(speed_low_slow) * m_left) ? 2'd1 : 2'd0;
                why = {tag, " R5 low"};
            end
        end else begin
            why = {tag, " R7 idle tick"};
        end
        @(posedge clk); #1;
        tick = 1'b0;
        q.push_back(cur(why));
    endtask

    // Monitor: compare outputs with the oldest expected item, away from the edge.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (volt_hi !== e.v || freq_sel !== e.f || clk_en !== e.e || deadline_miss !== e.m) begin
                errors++;
                $display("FAIL %s: actual v=%b f=%0d en=%b miss=%b expected v=%b f=%0d en=%b miss=%b",
                         e.tag, volt_hi, freq_sel, clk_en, deadline_miss, e.v, e.f, e.e, e.m);
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_active = 0; m_locked = 0; m_miss = 0; m_v = 0; m_f = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        q.push_back(cur("R1 reset state"));

        // Tick with no task: nothing changes (R7).
        do_tick(50, "R7 pre-task");

        // Task A: high phase, drop at exact tick, fast then slow low frequency (R3 R4 R5).
        load_task(1500, 20);
        repeat (7) do_tick(100, "R3 taskA");
        for (int i = 0; i < 20 && m_active; i++) do_tick(80, "R3 taskA low");
        do_tick(80, "R7 after done");
        do_tick(0, "R7 after done");

        // Task B: infeasible, stays high, then deadline miss held (R9 R8).
        load_task(5000, 10);
        for (int i = 0; i < 10; i++) do_tick(100, "R9 infeasible");
        do_tick(2000, "R8 overrun");
        for (int i = 0; i < 4 && m_active; i++) do_tick(2000, "R8 overrun");
        do_tick(10, "R8 miss held idle");

        // Task C: early drop then stalled work; must stay low until deadline (R6).
        load_task(1000, 40);
        do_tick(100, "R6 taskC");
        for (int i = 0; i < 39; i++) do_tick(0, "R6 stall");
        for (int i = 0; i < 4 && m_active; i++) do_tick(500, "R8 finish late");

        // Task D: work completes exactly on the last tick, no miss raised (R7).
        load_task(120, 2);
        do_tick(60, "R7 taskD");
        do_tick(60, "R7 last tick");

        repeat (3) @(posedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule